// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer with Two-Bit Prediction

This block sits beside the fetch stage and proposes the next fetch address each cycle. The fetch address selects one slot of a direct-mapped table. Each slot holds four things: a valid flag, the upper address bits of the branch that owns it, the address that branch jumped to, and a two-bit saturating counter. The target may only be used when the stored owner bits match the fetch address exactly. A match with a counter that leans toward taken redirects fetch to the stored target. Every other case falls through to the sequential address, fetch address plus four.

When a branch resolves later in the pipeline, its address, its actual target and its direction come back on an update port. A branch that hits in the table trains the counter of its slot. A taken branch that hits also refreshes the stored target. A taken branch that misses claims its slot, evicting whatever was there, and starts at weakly taken. A not-taken branch that misses leaves the table alone. The lookup path is purely combinational. Writes land on the rising clock edge, so a lookup in the same cycle as an update still sees the old contents.

Top module: `btb_top`

## Requirements
- R1: After a synchronous active-low reset every slot is invalid, so every lookup reports hit=0, taken=0 and next_pc = fetch_pc + 4.
- R2: A lookup whose slot is invalid reports hit=0, taken=0 and next_pc = fetch_pc + 4.
- R3: A taken update that misses allocates its slot with counter value 2 (weakly taken). The next lookup of that address hits and predicts taken, and a single later not-taken update turns the prediction to not-taken.
- R4: A not-taken update that misses writes nothing. A later lookup of that address still misses.
- R5: A hit requires the stored tag (fetch_pc bits above the index) to equal the fetch address tag. An address sharing the index but with a different tag misses.
- R6: A hit whose counter is 2 or 3 sets taken=1 and drives next_pc to the stored target.
- R7: A hit whose counter is 0 or 1 keeps hit=1, sets taken=0 and drives next_pc = fetch_pc + 4.
- R8: The counter encoding is 0 = strongly not-taken, 1 = weakly not-taken, 2 = weakly taken, 3 = strongly taken. A taken update on a hit adds one, saturating at 3. A not-taken update on a hit subtracts one, saturating at 0.
- R9: Updates take effect only at the rising clock edge. A lookup during the cycle of an update sees the contents from before that update.
- R10: A taken update that hits overwrites the stored target with the new target.
- R11: A taken update that misses on a valid slot owned by another tag replaces that slot. The old owner then misses.
- R12: Address bits [1:0] take part in neither the index nor the tag. The index is bits [IDX_W+1:2], and a stored target is kept word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| lk_hit | output | 1 | Valid slot with matching tag |
| lk_taken | output | 1 | Hit and counter predicts taken |
| next_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | PC_W | Actual target of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench walks one slot through the full counter range. A design that failed to saturate at either end would flip the prediction one update too early. A design that allocated at strongly taken would still predict taken after one not-taken update. The bench also probes an alias address that shares an index with a resident branch. A design without the full tag compare would redirect that alias to someone else's target. A design that allocated on not-taken misses would show a hit where none is due. Lookups made during an update cycle catch a write-through that leaks the new contents early, and a lookup with low address bits set catches those bits slipping into the index or tag.

// File: rtl/btb_pkg.sv
// Package: shared constants for the branch target buffer.
// Assumes a two-bit saturating counter whose upper bit is the prediction.
package btb_pkg;

    localparam int CTR_W = 2;

    localparam logic [CTR_W-1:0] CTR_STRONG_NT = 2'd0;
    localparam logic [CTR_W-1:0] CTR_WEAK_NT   = 2'd1;
    localparam logic [CTR_W-1:0] CTR_WEAK_T    = 2'd2;
    localparam logic [CTR_W-1:0] CTR_STRONG_T  = 2'd3;

    // Saturating step of a counter toward the resolved direction.
    function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] cur,
                                                  input logic             taken);
        logic [CTR_W-1:0] res;
        if (taken) begin
            res = (cur == CTR_STRONG_T) ? cur : cur + 1'b1;
        end else begin
            res = (cur == CTR_STRONG_NT) ? cur : cur - 1'b1;
        end
        return res;
    endfunction

endpackage

// File: rtl/btb_pc_split.sv
// Module: splits a word-aligned address into slot index and tag.
// Assumes bits [1:0] are byte offsets and carry no branch identity.
module btb_pc_split #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - 2 - IDX_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);

    logic low_bits_unused;

    // Slice the address into index and tag fields.
    always_comb begin
        idx = pc[IDX_W+1:2];
        tag = pc[PC_W-1:IDX_W+2];
    end

    assign low_bits_unused = ^pc[1:0];

endmodule

// File: rtl/btb_ctr_train.sv
// Module: computes the counter value to write on a resolved branch.
// Assumes a miss only ever writes when the branch was taken (allocation).
module btb_ctr_train
    import btb_pkg::*;
(
    input  logic             upd_hit,
    input  logic             upd_taken,
    input  logic [CTR_W-1:0] old_ctr,
    output logic [CTR_W-1:0] new_ctr
);

    // Train on hit, start weakly taken on allocation.
    always_comb begin
        if (upd_hit) begin
            new_ctr = ctr_step(old_ctr, upd_taken);
        end else begin
            new_ctr = CTR_WEAK_T;
        end
    end

endmodule

// File: rtl/btb_store.sv
// Module: slot storage with one write port and two combinational read ports.
// Assumes only valid flags and counters need reset; tags and targets are
// never read while the slot is invalid.
module btb_store
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - 2 - IDX_W,
    localparam int TGT_W = PC_W - 2,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    // write port
    input  logic             wr_en,
    input  logic             wr_tgt_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic [CTR_W-1:0] wr_ctr,
    // lookup read port
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_valid,
    output logic [TAG_W-1:0] lk_tag,
    output logic [TGT_W-1:0] lk_tgt,
    output logic [CTR_W-1:0] lk_ctr,
    // update read port
    input  logic [IDX_W-1:0] up_idx,
    output logic             up_valid,
    output logic [TAG_W-1:0] up_tag,
    output logic [CTR_W-1:0] up_ctr
);

    logic [DEPTH-1:0] valid_all;
    logic [TAG_W-1:0] tag_all [DEPTH];
    logic [TGT_W-1:0] tgt_all [DEPTH];
    logic [CTR_W-1:0] ctr_all [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic [TGT_W-1:0] g_q;
        logic [CTR_W-1:0] c_q;
        logic             hit_me;

        assign hit_me = wr_en && (wr_idx == IDX_W'(e));

        // Hold one slot; clear valid and counter on reset, write on select.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                c_q <= CTR_STRONG_NT;
            end else if (hit_me) begin
                v_q <= 1'b1;
                t_q <= wr_tag;
                c_q <= wr_ctr;
                if (wr_tgt_en) begin
                    g_q <= wr_tgt;
                end
            end
        end

        assign valid_all[e] = v_q;
        assign tag_all[e]   = t_q;
        assign tgt_all[e]   = g_q;
        assign ctr_all[e]   = c_q;
    end

    // Read the slot selected by the fetch address.
    always_comb begin
        lk_valid = valid_all[lk_idx];
        lk_tag   = tag_all[lk_idx];
        lk_tgt   = tgt_all[lk_idx];
        lk_ctr   = ctr_all[lk_idx];
    end

    // Read the slot selected by the resolving branch.
    always_comb begin
        up_valid = valid_all[up_idx];
        up_tag   = tag_all[up_idx];
        up_ctr   = ctr_all[up_idx];
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_all == '0)); // R1

    AST_ALLOC_WEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !valid_all[wr_idx]) |=> (ctr_all[$past(wr_idx)] == CTR_WEAK_T)); // R3

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && valid_all[wr_idx] && (tag_all[wr_idx] == wr_tag) && wr_tgt_en
         && (ctr_all[wr_idx] == CTR_STRONG_T))
        |=> (ctr_all[$past(wr_idx)] == CTR_STRONG_T)); // R8

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(valid_all)); // R4

endmodule

// File: rtl/btb_top.sv
// Module: direct-mapped branch target buffer with per-slot 2-bit counters.
// Lookup is combinational from fetch_pc; the update port writes on the
// rising edge. Assumes word-aligned addresses and one update per cycle.
module btb_top
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_taken
);

    localparam int TAG_W = PC_W - 2 - IDX_W;
    localparam int TGT_W = PC_W - 2;

    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic             s_lk_valid, s_up_valid;
    logic [TAG_W-1:0] s_lk_tag, s_up_tag;
    logic [TGT_W-1:0] s_lk_tgt;
    logic [CTR_W-1:0] s_lk_ctr, s_up_ctr;
    logic             upd_hit;
    logic             wr_en;
    logic [CTR_W-1:0] wr_ctr;
    logic [PC_W-1:0]  seq_pc;
    logic             tgt_low_unused;

    btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_fetch (
        .pc (fetch_pc),
        .idx(f_idx),
        .tag(f_tag)
    );

    btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_upd (
        .pc (upd_pc),
        .idx(u_idx),
        .tag(u_tag)
    );

    btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_tgt_en(upd_taken),
        .wr_idx   (u_idx),
        .wr_tag   (u_tag),
        .wr_tgt   (upd_target[PC_W-1:2]),
        .wr_ctr   (wr_ctr),
        .lk_idx   (f_idx),
        .lk_valid (s_lk_valid),
        .lk_tag   (s_lk_tag),
        .lk_tgt   (s_lk_tgt),
        .lk_ctr   (s_lk_ctr),
        .up_idx   (u_idx),
        .up_valid (s_up_valid),
        .up_tag   (s_up_tag),
        .up_ctr   (s_up_ctr)
    );

    btb_ctr_train u_train (
        .upd_hit  (upd_hit),
        .upd_taken(upd_taken),
        .old_ctr  (s_up_ctr),
        .new_ctr  (wr_ctr)
    );

    assign tgt_low_unused = ^upd_target[1:0];

    // Decide whether the resolving branch writes: train on hit, allocate on taken miss.
    always_comb begin
        upd_hit = s_up_valid && (s_up_tag == u_tag);
        wr_en   = upd_valid && (upd_hit || upd_taken);
    end

    // Form the prediction from the selected slot.
    always_comb begin
        seq_pc   = fetch_pc + PC_W'(4);
        lk_hit   = s_lk_valid && (s_lk_tag == f_tag);
        lk_taken = lk_hit && s_lk_ctr[CTR_W-1];
        next_pc  = lk_taken ? {s_lk_tgt, 2'b00} : seq_pc;
    end

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken |-> lk_hit); // R7

    AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (next_pc == fetch_pc + PC_W'(4))); // R2

    AST_NT_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && !upd_hit) |-> !wr_en); // R4

    AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        lk_taken |-> (next_pc[1:0] == 2'b00)); // R12

endmodule

// File: tb/btb_top_tb.sv
// Bench: directed scenarios for btb_top, one task each.
module btb_top_tb_top;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PC_W-1:0] fetch_pc;
    logic            lk_hit;
    logic            lk_taken;
    logic [PC_W-1:0] next_pc;
    logic            upd_valid;
    logic [PC_W-1:0] upd_pc;
    logic [PC_W-1:0] upd_target;
    logic            upd_taken;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [31:0] PC_A  = 32'h0000_1040; // slot 0
    localparam logic [31:0] PC_B  = 32'h0000_1080; // slot 0, other tag
    localparam logic [31:0] PC_C  = 32'h0000_2008; // slot 2
    localparam logic [31:0] TGT_1 = 32'h0000_4000;
    localparam logic [31:0] TGT_2 = 32'h0000_5010;
    localparam logic [31:0] TGT_3 = 32'h0000_6020;
    localparam logic [31:0] TGT_4 = 32'h0000_7030;

    always #2 clk = ~clk; // 250 MHz

    btb_top #(.PC_W(PC_W), .IDX_W(4)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_pc  (fetch_pc),
        .lk_hit    (lk_hit),
        .lk_taken  (lk_taken),
        .next_pc   (next_pc),
        .upd_valid (upd_valid),
        .upd_pc    (upd_pc),
        .upd_target(upd_target),
        .upd_taken (upd_taken)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present a lookup and check all three outputs.
    task automatic look(input string req, input logic [31:0] pc, input logic hit,
                        input logic tk, input logic [31:0] nxt);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        check({req, " hit"}, {31'd0, lk_hit}, {31'd0, hit});
        check({req, " taken"}, {31'd0, lk_taken}, {31'd0, tk});
        check({req, " next_pc"}, next_pc, nxt);
    endtask

    // Present one resolved branch for one edge.
    task automatic upd(input logic [31:0] pc, input logic [31:0] tgt, input logic tk);
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = pc;
        upd_target = tgt;
        upd_taken  = tk;
        @(negedge clk);
        upd_valid  = 1'b0;
    endtask

    task automatic t_reset;
        look("R1 reset A", PC_A, 1'b0, 1'b0, PC_A + 4);
        look("R1 reset C", PC_C, 1'b0, 1'b0, PC_C + 4);
        look("R2 empty slot", 32'h0000_300C, 1'b0, 1'b0, 32'h0000_3010);
    endtask

    task automatic t_nt_miss;
        upd(PC_A, TGT_1, 1'b0);
        look("R4 nt miss no alloc", PC_A, 1'b0, 1'b0, PC_A + 4);
    endtask

    task automatic t_alloc;
        upd(PC_A, TGT_1, 1'b1);                     // ctr 2
        look("R3 R6 alloc taken", PC_A, 1'b1, 1'b1, TGT_1);
        upd(PC_A, TGT_1, 1'b0);                     // ctr 1
        look("R3 R7 weak to nt", PC_A, 1'b1, 1'b0, PC_A + 4);
    endtask

    task automatic t_saturate;
        upd(PC_A, TGT_1, 1'b1);                     // 2
        upd(PC_A, TGT_1, 1'b1);                     // 3
        upd(PC_A, TGT_1, 1'b1);                     // 3 held
        upd(PC_A, TGT_1, 1'b0);                     // 2
        look("R8 high sat one nt", PC_A, 1'b1, 1'b1, TGT_1);
        upd(PC_A, TGT_1, 1'b0);                     // 1
        look("R8 two nt", PC_A, 1'b1, 1'b0, PC_A + 4);
        upd(PC_A, TGT_1, 1'b0);                     // 0
        upd(PC_A, TGT_1, 1'b0);                     // 0 held
        upd(PC_A, TGT_1, 1'b0);                     // 0 held
        upd(PC_A, TGT_1, 1'b1);                     // 1
        look("R8 low sat one t", PC_A, 1'b1, 1'b0, PC_A + 4);
        upd(PC_A, TGT_1, 1'b1);                     // 2
        look("R8 low sat two t", PC_A, 1'b1, 1'b1, TGT_1);
    endtask

    task automatic t_retarget;
        upd(PC_A, TGT_2, 1'b1);                     // 3
        look("R10 new target", PC_A, 1'b1, 1'b1, TGT_2);
    endtask

    task automatic t_alias;
        look("R5 alias misses", PC_B, 1'b0, 1'b0, PC_B + 4);
        upd(PC_B, TGT_3, 1'b1);
        look("R11 new owner", PC_B, 1'b1, 1'b1, TGT_3);
        look("R11 old owner evicted", PC_A, 1'b0, 1'b0, PC_A + 4);
    endtask

    task automatic t_low_bits;
        look("R12 low bits ignored", PC_B | 32'h2, 1'b1, 1'b1, TGT_3);
        upd(PC_C | 32'h1, TGT_4 | 32'h3, 1'b1);
        look("R12 aligned target", PC_C, 1'b1, 1'b1, TGT_4);
    endtask

    task automatic t_same_cycle;
        logic [31:0] pc_d;
        pc_d = 32'h0000_2010;                       // slot 4, empty
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = pc_d;
        upd_target = TGT_1;
        upd_taken  = 1'b1;
        fetch_pc   = pc_d;
        #1;
        check("R9 before edge hit", {31'd0, lk_hit}, 32'd0);
        check("R9 before edge next", next_pc, pc_d + 4);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        check("R9 after edge hit", {31'd0, lk_hit}, 32'd1);
        check("R9 after edge next", next_pc, TGT_1);
    endtask

    initial begin
        rst_n      = 1'b0;
        fetch_pc   = '0;
        upd_valid  = 1'b0;
        upd_pc     = '0;
        upd_target = '0;
        upd_taken  = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_nt_miss();
        t_alloc();
        t_saturate();
        t_retarget();
        t_alias();
        t_low_bits();
        t_same_cycle();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule